// File: doc/BRIEF.md
# NAND Flash Phase Sequencer with Address-Encoded Control

This block turns single-beat requests from a host into byte-wide cycles on an 8-bit NAND flash bus. The request does not point at any register. Its 32-bit address encodes the whole operation instead: which chip to select, whether this is a command phase or a data phase, the start and end command bytes, how many address bytes to send, and whether chip enable drops when the transfer ends. There is no control register. A host that wants to use the flash writes to and reads from crafted addresses.

A command phase sends one start command byte with CLE high. It then sends from zero to seven address bytes with ALE high, and then an optional end command. A data phase moves four bytes, either written from the request word or read into the response word, lowest byte first. Either phase can end with a command byte. After any end command the block waits a fixed settle time, then waits for the ready/busy line to go high, and only then completes. The host port follows valid/ready rules. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the cycle after the one-cycle `rsp_valid` pulse. The response has no back-pressure, so the host must take `rsp_valid` in the cycle it appears.

Top module: `nand_phase_seq`

## Requirements
- R1: During and right after reset, `req_ready` is 1, every `nand_ce_n` bit is 1, `nand_we_n` and `nand_re_n` are 1, and `nand_cle`, `nand_ale`, `nand_dq_oe` and `rsp_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Every taken request produces exactly one single-cycle `rsp_valid`. `req_ready` is 0 from the cycle after acceptance up to and including the `rsp_valid` cycle, and it is 1 again in the next cycle.
- R3: The low log2(NUM_CS) bits of address bits [31:24] choose which `nand_ce_n` bit is driven low. At most one bit is ever low. The selected chip stays enabled across requests until it is released.
- R4: When address bit 19 is 0 (command phase), the first byte sent is address bits [10:3], written with CLE high and ALE low.
- R5: In a command phase, address bits [23:21] give N, the number of address bytes. Up to four of them follow the start command with ALE high, taken from `req_wdata` starting at bits [7:0].
- R6: When N is 5 to 7, the request ends after four address bytes and holds back its end command. The next request, whatever its address and direction, supplies the remaining N-4 bytes from its `req_wdata` starting at bits [7:0]. The held end command follows those bytes.
- R7: When address bit 20 is 1, in either phase, address bits [18:11] are sent with CLE high as the final byte of the request, after all address or data bytes.
- R8: When address bit 19 is 1 (data phase), four bytes are transferred. A write sends `req_wdata` bytes [7:0] first through [31:24] last, using WE# strobes. A read uses RE# strobes and places the bytes into `rsp_rdata` in the same order, first byte in [7:0].
- R9: When a data-phase request has address bit 21 set, every `nand_ce_n` bit is 1 in the cycle after its `rsp_valid`.
- R10: `rsp_ecc_last` is 1 in the `rsp_valid` cycle exactly when the request was a data phase with address bit 10 set.
- R11: After an end command, `rsp_valid` is held back for T_WB cycles and then until `nand_rb` is 1.
- R12: Each byte takes T_SETUP cycles with the strobe high, then T_PULSE cycles with the strobe low, then T_HOLD cycles (at least one) with the strobe high. CLE, ALE and the output byte stay steady for the whole byte. WE# and RE# are never low together, and CLE and ALE are never high together.
- R13: `nand_dq_oe` is 0 while RE# is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 32 | Encoded operation address |
| req_wdata | input | 32 | Address bytes or write data |
| req_write | input | 1 | 1 for write, 0 for read (data phase only) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Bytes read in a data-phase read |
| rsp_ecc_last | output | 1 | Completion marks the last transfer of an ECC block |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Byte driven onto the flash bus |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Byte read from the flash bus |
| nand_rb | input | 1 | Ready/busy line, high when ready |

## Verification
The bench drives random mixes of the two phases and checks the order of every byte seen at the flash pins. A design that counted address bytes wrongly, or sent the end command before the data, would show a wrong byte stream. The split address case with five to seven bytes is driven both directly and at random, with continuation requests whose addresses are junk. A design that decoded that follow-up request as a fresh operation would issue an extra start command. A flash model drops ready/busy for a random time after each end command, which catches a design that completes early. The bench also checks chip-enable release, the ECC flag and read byte order after each request, so a design that lost release or swapped byte lanes would be reported.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // Field positions inside the encoded request address
  localparam int CHIP_LSB    = 24;
  localparam int NADDR_LSB   = 21;
  localparam int ENDOK_BIT   = 20;
  localparam int PHASE_BIT   = 19;
  localparam int ENDCMD_LSB  = 11;
  localparam int STARTCMD_LSB = 3;
  localparam int DROPCE_BIT  = 21;
  localparam int ECCLAST_BIT = 10;

  typedef struct packed {
    logic [7:0] chip;
    logic       data_ph;
    logic [2:0] naddr;
    logic       end_ok;
    logic [7:0] end_cmd;
    logic [7:0] start_cmd;
    logic       drop_ce;
    logic       ecc_tail;
  } op_fields_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_END,
    ST_WAITRB,
    ST_RESP
  } seq_state_t;

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
  import nand_seq_pkg::*;
(
  input  logic [31:0] bus_addr,
  output op_fields_t  fields
);

  logic unused_low_bits;
  assign unused_low_bits = ^bus_addr[2:0];

  always_comb begin
    fields.chip      = bus_addr[CHIP_LSB +: 8];
    fields.data_ph   = bus_addr[PHASE_BIT];
    fields.naddr     = bus_addr[NADDR_LSB +: 3];
    fields.end_ok    = bus_addr[ENDOK_BIT];
    fields.end_cmd   = bus_addr[ENDCMD_LSB +: 8];
    fields.start_cmd = bus_addr[STARTCMD_LSB +: 8];
    fields.drop_ce   = bus_addr[DROPCE_BIT];
    fields.ecc_tail  = bus_addr[ECCLAST_BIT];
  end

endmodule

// File: rtl/nand_byte_timer.sv
module nand_byte_timer #(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic strobe,
  output logic sample,
  output logic done
);

  localparam int TOTAL = T_SETUP + T_PULSE + T_HOLD;
  localparam int CW    = (TOTAL > 2) ? $clog2(TOTAL) : 1;
  localparam logic [CW-1:0] LAST_C   = CW'(TOTAL - 1);
  localparam logic [CW-1:0] PULSE_LO = CW'(T_SETUP);
  localparam logic [CW-1:0] PULSE_HI = CW'(T_SETUP + T_PULSE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en)            cnt <= '0;
    else if (cnt == LAST_C)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign strobe = en && (cnt >= PULSE_LO) && (cnt <= PULSE_HI);
  assign sample = en && (cnt == PULSE_HI);
  assign done   = en && (cnt == LAST_C);

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1,
  parameter int T_WB    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_ecc_last,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_i,
  input  logic              nand_rb
);

  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int WB_W = $clog2(T_WB + 1) + 1;
  localparam logic [WB_W-1:0] WB_LIMIT = WB_W'(T_WB);

  seq_state_t      state;
  op_fields_t      dec;
  op_fields_t      cur;
  logic [31:0]     wdata_q;
  logic            write_q;
  logic [1:0]      byte_idx;
  logic [1:0]      byte_last;
  logic [2:0]      cont_left;
  logic [CS_W-1:0] sel_chip;
  logic            ce_on;
  logic [31:0]     rdata_q;
  logic [WB_W-1:0] wb_cnt;

  logic            tmr_en, tmr_strobe, tmr_sample, tmr_done;
  logic            rd_now;
  logic            accept;

  logic unused_sink;
  assign unused_sink = ^{dec.chip, cur.chip};

  nand_addr_decode u_dec (
    .bus_addr (req_addr),
    .fields   (dec)
  );

  assign tmr_en = (state == ST_CMD) || (state == ST_ADDR) ||
                  (state == ST_DATA) || (state == ST_END);

  nand_byte_timer #(
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (tmr_en),
    .strobe (tmr_strobe),
    .sample (tmr_sample),
    .done   (tmr_done)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_now    = (state == ST_DATA) && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur       <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      byte_idx  <= '0;
      byte_last <= '0;
      cont_left <= '0;
      sel_chip  <= '0;
      ce_on     <= 1'b0;
      rdata_q   <= '0;
      wb_cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            wdata_q  <= req_wdata;
            byte_idx <= '0;
            if (cont_left != 3'd0) begin
              // continuation of a long address sequence
              write_q     <= 1'b1;
              cur.data_ph <= 1'b0;
              byte_last   <= 2'(cont_left - 3'd1);
              cont_left   <= '0;
              state       <= ST_ADDR;
            end else begin
              cur      <= dec;
              write_q  <= req_write;
              sel_chip <= dec.chip[CS_W-1:0];
              ce_on    <= 1'b1;
              if (dec.data_ph) begin
                byte_last <= 2'd3;
                state     <= ST_DATA;
              end else begin
                state <= ST_CMD;
              end
            end
          end
        end

        ST_CMD: begin
          if (tmr_done) begin
            if (cur.naddr != 3'd0) begin
              state    <= ST_ADDR;
              byte_idx <= '0;
              if (cur.naddr > 3'd4) begin
                byte_last <= 2'd3;
                cont_left <= cur.naddr - 3'd4;
              end else begin
                byte_last <= 2'(cur.naddr - 3'd1);
                cont_left <= '0;
              end
            end else begin
              state <= cur.end_ok ? ST_END : ST_RESP;
            end
          end
        end

        ST_ADDR: begin
          if (tmr_done) begin
            if (byte_idx == byte_last) begin
              if (cont_left != 3'd0) state <= ST_RESP;
              else                   state <= cur.end_ok ? ST_END : ST_RESP;
            end else begin
              byte_idx <= byte_idx + 2'd1;
            end
          end
        end

        ST_DATA: begin
          if (tmr_sample && !write_q) rdata_q[8*byte_idx +: 8] <= nand_dq_i;
          if (tmr_done) begin
            if (byte_idx == byte_last) state <= cur.end_ok ? ST_END : ST_RESP;
            else                       byte_idx <= byte_idx + 2'd1;
          end
        end

        ST_END: begin
          if (tmr_done) begin
            state  <= ST_WAITRB;
            wb_cnt <= '0;
          end
        end

        ST_WAITRB: begin
          if (wb_cnt < WB_LIMIT) wb_cnt <= wb_cnt + 1'b1;
          else if (nand_rb)      state  <= ST_RESP;
        end

        ST_RESP: begin
          state <= ST_IDLE;
          if (cur.data_ph && cur.drop_ce) ce_on <= 1'b0;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_CMD:  nand_dq_o = cur.start_cmd;
      ST_ADDR: nand_dq_o = wdata_q[8*byte_idx +: 8];
      ST_DATA: nand_dq_o = write_q ? wdata_q[8*byte_idx +: 8] : 8'h00;
      ST_END:  nand_dq_o = cur.end_cmd;
      default: nand_dq_o = 8'h00;
    endcase
  end

  assign nand_cle   = (state == ST_CMD) || (state == ST_END);
  assign nand_ale   = (state == ST_ADDR);
  assign nand_we_n  = !(tmr_strobe && !rd_now);
  assign nand_re_n  = !(tmr_strobe && rd_now);
  assign nand_dq_oe = nand_cle || nand_ale || ((state == ST_DATA) && write_q);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CS; gi++) begin : g_ce
      assign nand_ce_n[gi] = !(ce_on && (sel_chip == CS_W'(gi)));
    end
  endgenerate

  assign rsp_valid    = (state == ST_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_ecc_last = (state == ST_RESP) && cur.data_ph && cur.ecc_tail;

endmodule

// File: rtl/nand_phase_seq_chk.sv
module nand_phase_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic [7:0]        nand_dq_o,
  input logic              nand_dq_oe
);

  p_ce_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_latch_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);

  p_resp_then_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && !rsp_valid));

  p_we_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  p_re_floats_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_dq_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(nand_we_n) && nand_we_n) |-> (nand_dq_o == $past(nand_dq_o)));

endmodule

bind nand_phase_seq nand_phase_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_o  (nand_dq_o),
  .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_phase_seq_bench.sv
module nand_phase_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int TS  = 2;
  localparam int TP  = 2;
  localparam int TH  = 1;
  localparam int TWB = 4;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid, rsp_ecc_last;
  logic [31:0] rsp_rdata;
  logic [NCS-1:0] nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb;

  nand_phase_seq #(
    .NUM_CS(NCS), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_WB(TWB)
  ) u_nand_phase_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ecc_last(rsp_ecc_last),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdv(input int n);
    return 8'((n * 37) ^ 90);
  endfunction

  // ---------------- flash model, observes pins at falling clock edges
  int          ev_type [0:15];
  logic [7:0]  ev_val  [0:15];
  logic [NCS-1:0] ev_ce [0:15];
  int          ev_n = 0;
  int          rd_cnt = 0;
  int          busy_ev = -1;
  int          busy_len = 5;
  int          busy_cnt = 0;
  bit          busy_seen = 0;
  bit          prev_low = 0;
  int          lowcnt = 0;
  int          highcnt = 100;

  assign nand_dq_i = rdv(rd_cnt);

  always @(negedge clk) begin
    bit low_now;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) nand_rb = 1'b1;
    end
    low_now = !nand_we_n || !nand_re_n;
    if (low_now) begin
      if (!prev_low) begin
        chk(highcnt >= TS + TH, "R12 strobe gap", highcnt, TS + TH);
        highcnt = 0;
      end
      lowcnt++;
    end else begin
      if (prev_low) begin
        chk(lowcnt == TP, "R12 pulse width", lowcnt, TP);
        lowcnt = 0;
        if (ev_n < 16) begin
          ev_ce[ev_n] = nand_ce_n;
          if (nand_re_n == 1'b1 && u_was_read == 1'b0) begin
            ev_type[ev_n] = nand_cle ? 1 : (nand_ale ? 2 : 3);
            ev_val[ev_n]  = nand_dq_o;
            if (nand_cle && ev_n == busy_ev) begin
              nand_rb   = 1'b0;
              busy_cnt  = busy_len;
              busy_seen = 1'b1;
            end
          end else begin
            ev_type[ev_n] = 0;
            ev_val[ev_n]  = nand_dq_i;
            rd_cnt++;
          end
        end
        ev_n++;
      end
      highcnt++;
    end
    prev_low = low_now;
  end

  // remembers whether the strobe that just ended was a read strobe
  logic u_was_read = 1'b0;
  always @(negedge clk) begin
    if (!nand_re_n) begin
      chk(!nand_dq_oe, "R13 dq_oe during RE#", nand_dq_oe, 0);
    end
  end
  always @(posedge clk) u_was_read <= !nand_re_n ? 1'b1 : (!nand_we_n ? 1'b0 : u_was_read);

  // ---------------- expected-trace bookkeeping
  int          exp_type [0:15];
  logic [7:0]  exp_val  [0:15];
  int          exp_n;
  int          exp_rd_cnt = 0;
  int          pend_left = 0;
  bit          pend_end_ok = 0;
  logic [7:0]  pend_end = 8'h00;
  int          cur_chip = 0;

  function automatic string ev_tag(input int t);
    case (t)
      0: return "R8 read byte";
      1: return "R4/R7 command byte";
      2: return "R5/R6 address byte";
      default: return "R8 write byte";
    endcase
  endfunction

  task automatic push(input int t, input logic [7:0] v);
    exp_type[exp_n] = t;
    exp_val[exp_n]  = v;
    exp_n++;
  endtask

  task automatic run_req(input logic [31:0] a, input logic [31:0] wd, input logic wr);
    bit isdata, has_end, cont, early_ready, timed_out;
    logic [31:0] exp_rd;
    logic [NCS-1:0] exp_ce;
    int cyc, n, k;
    exp_n = 0;
    exp_rd = '0;
    cont = (pend_left != 0);
    isdata = a[19];
    has_end = 0;
    if (cont) begin
      isdata = 0;
      for (int i = 0; i < pend_left; i++) push(2, wd[8*i +: 8]);
      has_end = pend_end_ok;
      if (has_end) push(1, pend_end);
      pend_left = 0;
    end else begin
      cur_chip = int'(a[25:24]);
      if (!isdata) begin
        push(1, a[10:3]);
        n = int'(a[23:21]);
        k = (n > 4) ? 4 : n;
        for (int i = 0; i < k; i++) push(2, wd[8*i +: 8]);
        if (n > 4) begin
          pend_left = n - 4;
          pend_end_ok = a[20];
          pend_end = a[18:11];
        end else begin
          has_end = a[20];
          if (has_end) push(1, a[18:11]);
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          if (wr) push(3, wd[8*i +: 8]);
          else begin
            push(0, rdv(exp_rd_cnt));
            exp_rd[8*i +: 8] = rdv(exp_rd_cnt);
            exp_rd_cnt++;
          end
        end
        has_end = a[20];
        if (has_end) push(1, a[18:11]);
      end
    end
    busy_ev = has_end ? exp_n - 1 : -1;
    busy_len = $urandom_range(3, 20);
    busy_seen = 0;
    ev_n = 0;

    @(negedge clk);
    chk(req_ready, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    early_ready = 0;
    cyc = 0;
    while (!rsp_valid && cyc < 3000) begin
      if (req_ready) early_ready = 1;
      @(negedge clk);
      cyc++;
    end
    timed_out = (cyc >= 3000);
    chk(!timed_out, "R2 response arrives", cyc, 0);
    chk(!early_ready, "R2 ready low while busy", early_ready, 0);
    chk(ev_n == exp_n, "R4/R5/R7/R8 byte count", ev_n, exp_n);
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      chk(ev_type[i] == exp_type[i] && ev_val[i] == exp_val[i], ev_tag(exp_type[i]),
          {ev_type[i][7:0], 16'h0, ev_val[i]}, {exp_type[i][7:0], 16'h0, exp_val[i]});
      chk(ev_ce[i] == ~(NCS'(1) << cur_chip), "R3 chip enable during byte", ev_ce[i], ~(NCS'(1) << cur_chip));
    end
    if (has_end) chk(busy_seen && nand_rb, "R11 waits for ready/busy", {busy_seen, nand_rb}, 2'b11);
    if (isdata && !wr) chk(rsp_rdata == exp_rd, "R8 read word", rsp_rdata, exp_rd);
    chk(rsp_ecc_last == (isdata && a[10]), "R10 ecc last flag", rsp_ecc_last, isdata && a[10]);
    @(negedge clk);
    exp_ce = (isdata && a[21]) ? '1 : ~(NCS'(1) << cur_chip);
    chk(nand_ce_n == exp_ce, "R9 chip enable after response", nand_ce_n, exp_ce);
    chk(req_ready && !rsp_valid, "R2 ready after response", {req_ready, rsp_valid}, 2'b10);
  endtask

  function automatic logic [31:0] mk_addr(input int chip, input bit data, input int naddr,
                                          input bit endok, input logic [7:0] endc,
                                          input logic [7:0] startc);
    logic [31:0] a;
    a = '0;
    a[31:24] = 8'(chip);
    a[19] = data;
    a[20] = endok;
    a[18:11] = endc;
    if (!data) begin
      a[23:21] = 3'(naddr);
      a[10:3] = startc;
    end
    return a;
  endfunction

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_write = 1'b0;
    nand_rb = 1'b1;
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    chk(nand_ce_n == '1, "R1 chip enables high", nand_ce_n, '1);
    chk(nand_we_n && nand_re_n, "R1 strobes high", {nand_we_n, nand_re_n}, 2'b11);
    chk(!nand_cle && !nand_ale && !nand_dq_oe && !rsp_valid, "R1 latches idle",
        {nand_cle, nand_ale, nand_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && nand_ce_n == '1, "R1 after reset", {req_ready, nand_ce_n}, {1'b1, {NCS{1'b1}}});

    // directed corner cases
    run_req(mk_addr(0, 0, 0, 0, 8'h00, 8'hFF), 32'h0, 1'b1);                 // bare start command
    run_req(mk_addr(1, 0, 3, 1, 8'h30, 8'h00), 32'h00A1B2C3, 1'b1);          // addresses plus end
    run_req(mk_addr(1, 1, 0, 0, 8'h00, 8'h00), 32'h0, 1'b0);                 // data read
    run_req(mk_addr(2, 0, 5, 1, 8'h10, 8'h80), 32'h44332211, 1'b1);          // R6 long address
    run_req(32'hFFFF_FFFF, 32'h000000E5, 1'b0);                              // R6 continuation
    run_req(mk_addr(2, 1, 0, 1, 8'h70, 8'h00) | 32'h0000_0400, 32'hDEADBEEF, 1'b1); // ecc + end
    run_req(mk_addr(3, 0, 7, 0, 8'h00, 8'h05), 32'h87654321, 1'b1);          // 7 addresses, no end
    run_req(32'h0000_0000, 32'h00CCBBAA, 1'b1);                              // continuation, 3 bytes
    run_req(mk_addr(3, 1, 0, 0, 8'h00, 8'h00) | 32'h0020_0400, 32'h0, 1'b0); // release + ecc read

    // constrained random traffic
    for (int it = 0; it < 120; it++) begin
      logic [31:0] a, wd;
      logic wr;
      a = $urandom;
      wd = $urandom;
      wr = $urandom_range(0, 1);
      if (!a[19]) wr = 1'b1;
      run_req(a, wd, wr);
    end
    if (pend_left != 0) run_req($urandom, $urandom, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule